// File: doc/BRIEF.md
# UART RTS/CTS Flow and RS-485 Direction Control

This block produces the RTS pin level for a UART channel and decides whether the transmitter may begin its next character. It picks one of three sources for RTS, each overriding the ones below it. Lowest is a software request bit. Above it is receive-FIFO flow control, with a halt level and a resume level. Highest is automatic RS-485 driver-direction control.

Receive-FIFO flow control raises RTS when the receive FIFO reaches the halt level. It lowers RTS once the FIFO has drained to the resume level, and it holds RTS in the band between the two levels. Direction control asserts RTS as soon as a byte is pushed into the transmit FIFO. It keeps RTS asserted until the FIFO is empty and the shifter has completed its last stop bit. An invert bit flips the RTS level in this mode only.

The CTS pin passes through a two-flop synchronizer. When CTS gating is enabled, the transmit-permit output is withheld while the synchronized CTS is HIGH. The shifter samples the permit only before it starts a character, so a character already in progress always completes.

Top module: `uart_rts_ctl`

## Requirements
- R1: After reset, `rts_pin` is 1 (inactive) and `tx_permit` is 1.
- R2: With `dir_auto_en`=0 and `flow_rts_en`=0, `rts_pin` becomes the inverse of `sw_rts_assert` one clock after it is sampled. A request bit of 1 drives the pin LOW.
- R3: With flow control selected, `rts_pin` becomes 1 one clock after `rx_level` is at or above the halt level. The halt level is `halt_nib`×4.
- R4: With flow control selected, `rts_pin` becomes 0 one clock after `rx_level` is at or below the resume level (`resume_nib`×4) and below the halt level.
- R5: With flow control selected and `rx_level` strictly between the two levels, `rts_pin` keeps its previous value.
- R6: Direction control (`dir_auto_en`=1) overrides flow control, and flow control (`flow_rts_en`=1) overrides the software bit.
- R7: In direction mode with `dir_invert`=0, a `tx_push` drives `rts_pin` to 0 on the next clock. A push in the same cycle as the end condition still counts as pending.
- R8: In direction mode, RTS stays at its active level until both `tx_fifo_empty` and `tx_shift_idle` are 1. One clock later it returns to the idle level: 1 when normal, 0 when inverted. Empty alone does not release it.
- R9: With `dir_invert`=1 in direction mode, the active level is 1 and the idle level is 0.
- R10: With `flow_cts_en`=1, `tx_permit` is 0 three clocks after `cts_pin` is 1, and 1 three clocks after `cts_pin` is 0. With `flow_cts_en`=0, `tx_permit` is 1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rts_assert | input | 1 | Software RTS request (1 = pin LOW) |
| flow_rts_en | input | 1 | Enable receive-FIFO RTS flow control |
| flow_cts_en | input | 1 | Enable CTS gating of transmit start |
| dir_auto_en | input | 1 | Enable RS-485 automatic direction control |
| dir_invert | input | 1 | Invert RTS level in direction mode |
| halt_nib | input | 4 | Halt level in units of 4 entries |
| resume_nib | input | 4 | Resume level in units of 4 entries |
| rx_level | input | 7 | Receive FIFO fill count |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_idle | input | 1 | Shifter idle, last stop bit finished |
| cts_pin | input | 1 | CTS pin, asynchronous |
| rts_pin | output | 1 | RTS pin level, registered |
| tx_permit | output | 1 | Transmitter may start the next character |

## Verification
A push into the transmit FIFO can arrive in the same cycle as the end condition (FIFO empty and shifter idle). The bench provokes this by pulsing `tx_push` while both end flags are held at 1. The correct result is that RTS stays at its active level and is not released. A second collision is a change of mode in the same cycle that the flow-control threshold is crossed. The bench's behavioural model, compared every clock, decides which source owns that next RTS value.

// File: rtl/rtsc_pkg.sv
package rtsc_pkg;
  typedef enum logic [1:0] {
    SRC_MANUAL = 2'd0,
    SRC_FLOW   = 2'd1,
    SRC_DIR    = 2'd2
  } rts_src_e;

  function automatic rts_src_e pick_src(input logic dir_en, input logic flow_en);
    if (dir_en)       return SRC_DIR;
    else if (flow_en) return SRC_FLOW;
    else              return SRC_MANUAL;
  endfunction
endpackage

// File: rtl/rtsc_cts_gate.sv
module rtsc_cts_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_en,
  input  logic cts_pin,
  output logic permit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   permit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '0;
      permit_q <= 1'b1;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], cts_pin};
      permit_q <= ~gate_en | ~sync_q[SYNC_STAGES-1];
    end
  end

  assign permit = permit_q;
endmodule

// File: rtl/rtsc_flow_hyst.sv
module rtsc_flow_hyst #(
  parameter int LVL_W    = 7,
  parameter int NIB_W    = 4,
  parameter int SCALE_SH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic [NIB_W-1:0] halt_nib,
  input  logic [NIB_W-1:0] resume_nib,
  output logic             halt_next
);
  localparam int THR_W = NIB_W + SCALE_SH;

  logic [THR_W-1:0] halt_thr, resume_thr;
  logic [LVL_W-1:0] halt_lvl, resume_lvl;
  logic             halt_q;

  assign halt_thr   = {halt_nib, {SCALE_SH{1'b0}}};
  assign resume_thr = {resume_nib, {SCALE_SH{1'b0}}};
  assign halt_lvl   = LVL_W'(halt_thr);
  assign resume_lvl = LVL_W'(resume_thr);

  always_comb begin
    if (level >= halt_lvl)        halt_next = 1'b1;
    else if (level <= resume_lvl) halt_next = 1'b0;
    else                          halt_next = halt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) halt_q <= 1'b0;
    else     halt_q <= halt_next;
  end
endmodule

// File: rtl/rtsc_dir_track.sv
module rtsc_dir_track (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic fifo_empty,
  input  logic shift_idle,
  output logic active_next
);
  logic pending_q;
  logic drained;

  assign drained     = fifo_empty & shift_idle;
  assign active_next = push | (pending_q & ~drained);

  always_ff @(posedge clk) begin
    if (rst) pending_q <= 1'b0;
    else     pending_q <= active_next;
  end
endmodule

// File: rtl/uart_rts_ctl.sv
module uart_rts_ctl
  import rtsc_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int NIB_W       = 4,
  parameter int SCALE_SH    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rts_assert,
  input  logic             flow_rts_en,
  input  logic             flow_cts_en,
  input  logic             dir_auto_en,
  input  logic             dir_invert,
  input  logic [NIB_W-1:0] halt_nib,
  input  logic [NIB_W-1:0] resume_nib,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_push,
  input  logic             tx_fifo_empty,
  input  logic             tx_shift_idle,
  input  logic             cts_pin,
  output logic             rts_pin,
  output logic             tx_permit
);
  logic     flow_halt_d;
  logic     dir_active_d;
  logic     rts_d;
  logic     rts_q;
  rts_src_e src;

  rtsc_flow_hyst #(
    .LVL_W(LVL_W), .NIB_W(NIB_W), .SCALE_SH(SCALE_SH)
  ) u_hyst (
    .clk(clk), .rst(rst), .level(rx_level),
    .halt_nib(halt_nib), .resume_nib(resume_nib),
    .halt_next(flow_halt_d)
  );

  rtsc_dir_track u_dir (
    .clk(clk), .rst(rst), .push(tx_push),
    .fifo_empty(tx_fifo_empty), .shift_idle(tx_shift_idle),
    .active_next(dir_active_d)
  );

  rtsc_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst(rst), .gate_en(flow_cts_en),
    .cts_pin(cts_pin), .permit(tx_permit)
  );

  assign src = pick_src(dir_auto_en, flow_rts_en);

  always_comb begin
    unique case (src)
      SRC_DIR:  rts_d = dir_active_d ? dir_invert : ~dir_invert;
      SRC_FLOW: rts_d = flow_halt_d;
      default:  rts_d = ~sw_rts_assert;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rts_q <= 1'b1;
    else     rts_q <= rts_d;
  end

  assign rts_pin = rts_q;
endmodule

// File: rtl/uart_rts_ctl_checker.sv
module uart_rts_ctl_checker #(
  parameter int LVL_W    = 7,
  parameter int NIB_W    = 4,
  parameter int SCALE_SH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_rts_assert,
  input logic             flow_rts_en,
  input logic             flow_cts_en,
  input logic             dir_auto_en,
  input logic             dir_invert,
  input logic [NIB_W-1:0] halt_nib,
  input logic [NIB_W-1:0] resume_nib,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_push,
  input logic             tx_fifo_empty,
  input logic             tx_shift_idle,
  input logic             cts_pin,
  input logic             rts_pin,
  input logic             tx_permit
);
  int unsigned halt_v, resume_v, lvl_v;
  logic        flow_sel, above, at_low, between;

  assign halt_v   = int'(halt_nib) << SCALE_SH;
  assign resume_v = int'(resume_nib) << SCALE_SH;
  assign lvl_v    = int'(rx_level);
  assign flow_sel = !dir_auto_en && flow_rts_en;
  assign above    = lvl_v >= halt_v;
  assign at_low   = !above && lvl_v <= resume_v;
  assign between  = !above && !at_low;

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rts_pin && tx_permit));

  a_r2_manual: assert property (@(posedge clk) disable iff (rst)
    (!dir_auto_en && !flow_rts_en) |=> (rts_pin == !$past(sw_rts_assert)));

  a_r3_halt: assert property (@(posedge clk) disable iff (rst)
    (flow_sel && above) |=> rts_pin);

  a_r4_resume: assert property (@(posedge clk) disable iff (rst)
    (flow_sel && at_low) |=> !rts_pin);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (flow_sel && between && !$past(rst) && $past(flow_sel)) |=> (rts_pin == $past(rts_pin)));

  a_r7_push_assert: assert property (@(posedge clk) disable iff (rst)
    (dir_auto_en && tx_push && !dir_invert) |=> !rts_pin);

  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (dir_auto_en && !tx_push && tx_fifo_empty && tx_shift_idle) |=> (rts_pin == !$past(dir_invert)));

  a_r9_invert_push: assert property (@(posedge clk) disable iff (rst)
    (dir_auto_en && tx_push && dir_invert) |=> rts_pin);

  a_r10_block: assert property (@(posedge clk) disable iff (rst)
    (flow_cts_en && $past(cts_pin, 2) && !$past(rst) && !$past(rst, 2)) |=> !tx_permit);

  a_r10_open: assert property (@(posedge clk) disable iff (rst)
    !flow_cts_en |=> tx_permit);
endmodule

bind uart_rts_ctl uart_rts_ctl_checker #(
  .LVL_W(LVL_W), .NIB_W(NIB_W), .SCALE_SH(SCALE_SH)
) u_checker (
  .clk(clk), .rst(rst), .sw_rts_assert(sw_rts_assert),
  .flow_rts_en(flow_rts_en), .flow_cts_en(flow_cts_en),
  .dir_auto_en(dir_auto_en), .dir_invert(dir_invert),
  .halt_nib(halt_nib), .resume_nib(resume_nib), .rx_level(rx_level),
  .tx_push(tx_push), .tx_fifo_empty(tx_fifo_empty), .tx_shift_idle(tx_shift_idle),
  .cts_pin(cts_pin), .rts_pin(rts_pin), .tx_permit(tx_permit)
);

// File: tb/uart_rts_ctl_bench.sv
module uart_rts_ctl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_rts_assert = 1'b0, flow_rts_en = 1'b0, flow_cts_en = 1'b0;
  logic       dir_auto_en = 1'b0, dir_invert = 1'b0;
  logic [3:0] halt_nib = 4'd8, resume_nib = 4'd2;
  logic [6:0] rx_level = '0;
  logic       tx_push = 1'b0, tx_fifo_empty = 1'b1, tx_shift_idle = 1'b1;
  logic       cts_pin = 1'b0;
  logic       rts_pin, tx_permit;

  int    checks = 0, failures = 0, cycles = 0;
  string phase = "R1 reset";

  // behavioural reference state
  bit m_rts = 1, m_perm = 1, m_pend = 0, m_halt = 0, m_s1 = 0, m_s2 = 0;

  always #5 clk = ~clk;

  uart_rts_ctl u_uart_rts_ctl (
    .clk(clk), .rst(rst), .sw_rts_assert(sw_rts_assert),
    .flow_rts_en(flow_rts_en), .flow_cts_en(flow_cts_en),
    .dir_auto_en(dir_auto_en), .dir_invert(dir_invert),
    .halt_nib(halt_nib), .resume_nib(resume_nib), .rx_level(rx_level),
    .tx_push(tx_push), .tx_fifo_empty(tx_fifo_empty), .tx_shift_idle(tx_shift_idle),
    .cts_pin(cts_pin), .rts_pin(rts_pin), .tx_permit(tx_permit)
  );

  always @(posedge clk) begin
    int  lvl, hi, lo;
    bit  act;
    cycles++;
    if (rst) begin
      m_rts = 1; m_perm = 1; m_pend = 0; m_halt = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      m_perm = !flow_cts_en || !m_s2;
      m_s2   = m_s1;
      m_s1   = cts_pin;
      lvl = rx_level; hi = halt_nib * 4; lo = resume_nib * 4;
      if (lvl >= hi)      m_halt = 1;
      else if (lvl <= lo) m_halt = 0;
      act    = tx_push || (m_pend && !(tx_fifo_empty && tx_shift_idle));
      m_pend = act;
      if (dir_auto_en)      m_rts = act ? dir_invert : !dir_invert;
      else if (flow_rts_en) m_rts = m_halt;
      else                  m_rts = !sw_rts_assert;
    end
  end

  task automatic compare();
    checks++;
    if (rts_pin !== m_rts || tx_permit !== m_perm) begin
      failures++;
      $display("FAIL %s: rts=%0b perm=%0b expected rts=%0b perm=%0b",
               phase, rts_pin, tx_permit, m_rts, m_perm);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      compare();
    end
  endtask

  task automatic expect_rts(input bit exp, input string tag);
    checks++;
    if (rts_pin !== exp) begin
      failures++;
      $display("FAIL %s: rts=%0b expected %0b", tag, rts_pin, exp);
    end
  endtask

  task automatic expect_perm(input bit exp, input string tag);
    checks++;
    if (tx_permit !== exp) begin
      failures++;
      $display("FAIL %s: permit=%0b expected %0b", tag, tx_permit, exp);
    end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    expect_rts(1, "R1 reset rts"); expect_perm(1, "R1 reset permit");

    phase = "R2 manual";
    sw_rts_assert = 1; tick(1); expect_rts(0, "R2 request low");
    sw_rts_assert = 0; tick(1); expect_rts(1, "R2 release high");
    sw_rts_assert = 1; tick(2);

    phase = "R3 R4 R5 flow";
    flow_rts_en = 1; rx_level = 7'd0; tick(1); expect_rts(0, "R4 empty fifo");
    rx_level = 7'd20; tick(2); expect_rts(0, "R5 hold low");
    rx_level = 7'd31; tick(1); expect_rts(0, "R3 just below halt");
    rx_level = 7'd32; tick(1); expect_rts(1, "R3 at halt");
    rx_level = 7'd40; tick(1); expect_rts(1, "R3 above halt");
    rx_level = 7'd9;  tick(2); expect_rts(1, "R5 hold high");
    rx_level = 7'd8;  tick(1); expect_rts(0, "R4 at resume");
    halt_nib = 4'd3; resume_nib = 4'd1; rx_level = 7'd12; tick(1);
    expect_rts(1, "R3 scaled halt 12");
    rx_level = 7'd4; tick(1); expect_rts(0, "R4 scaled resume 4");

    phase = "R6 priority";
    rx_level = 7'd40; tick(1); expect_rts(1, "R6 flow over sw");
    dir_auto_en = 1; dir_invert = 1; tick(1); expect_rts(0, "R6 dir over flow");
    dir_auto_en = 0; tick(1); expect_rts(1, "R6 back to flow");
    flow_rts_en = 0; tick(1); expect_rts(0, "R6 back to sw");

    phase = "R7 R8 dir normal";
    dir_auto_en = 1; dir_invert = 0; tick(1); expect_rts(1, "R8 idle high");
    tx_push = 1; tick(1); expect_rts(0, "R7 push asserts");
    tx_push = 0; tx_fifo_empty = 0; tx_shift_idle = 0; tick(3);
    tx_fifo_empty = 1; tick(2); expect_rts(0, "R8 empty alone holds");
    tx_shift_idle = 1; tick(1); expect_rts(1, "R8 release after stop");
    tx_push = 1; tick(1); expect_rts(0, "R7 push while drained");
    tx_push = 0; tick(1); expect_rts(1, "R8 drained release");
    tx_push = 1; tx_fifo_empty = 0; tx_shift_idle = 0; tick(1);
    tx_push = 0; tx_fifo_empty = 1; tx_shift_idle = 1; tx_push = 1; tick(1);
    expect_rts(0, "R7 push in end cycle");
    tx_push = 0; tick(1); expect_rts(1, "R8 later release");

    phase = "R9 dir inverted";
    dir_invert = 1; tick(1); expect_rts(0, "R9 idle low");
    tx_push = 1; tick(1); expect_rts(1, "R9 push high");
    tx_push = 0; tx_fifo_empty = 0; tx_shift_idle = 0; tick(2);
    tx_fifo_empty = 1; tx_shift_idle = 1; tick(1); expect_rts(0, "R9 release low");
    dir_auto_en = 0; dir_invert = 0;

    phase = "R10 cts";
    cts_pin = 1; tick(4); expect_perm(1, "R10 gating off");
    flow_cts_en = 1; tick(1); expect_perm(0, "R10 block");
    cts_pin = 0; tick(2); expect_perm(0, "R10 sync delay");
    tick(1); expect_perm(1, "R10 open after 3");
    cts_pin = 1; tick(3); expect_perm(0, "R10 blocked after 3");
    flow_cts_en = 0; tick(1); expect_perm(1, "R10 disable opens");
    tick(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 5000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule